// File: doc/BRIEF.md
# Dual-Group Pattern Output Sequencer

The block stores output patterns in two groups of ten stages each and presents them one stage at a time on a parallel output. Each counted edge of an external pulse input moves the output forward by exactly one stage. The pulse input is asynchronous, so it passes through a synchronizer before edge detection, and a control bit chooses whether rising or falling edges are counted. In the default mode the block plays a twenty-step loop: every stage of the first group, then every stage of the second group, then back to the first. In the alternative mode it loops over the first group alone. A group flag tells software which group produced the pattern now on the output, so the other group can be refilled while it is idle.

Software loads patterns and settings through a small register write port. Each group is filled by repeated writes to its own push address, and its write pointer wraps after the last stage. A pass over a group copies that group's contents as its first stage goes out. Writes made during the pass therefore only show up on the following pass. Moving the mode bit from twenty-stage to ten-stage and back again restarts the output side at the first group. An interrupt request pulse is raised either on a rising edge of an external strobe or when the output pattern begins to equal a programmable compare value. Each request also sets a sticky bit that software clears.

Top module: `dual_pattern_seq`

## Requirements
- R1: Control register bit 0 selects the counted pulse edge: 0 (the reset value) counts rising edges of `pulse_i`, and 1 counts falling edges. The other edge has no effect on the output.
- R2: With control bit 1 at 0 (the reset value), successive counted edges present group-one stages 0 through 9, then group-two stages 0 through 9, and the loop repeats.
- R3: With control bit 1 at 1, only group-one stages are presented, and stage 9 is followed by stage 0 of group one. Group-two data never appears, and the group flag stays 0.
- R4: `grp_flag_o` is 0 when the pattern on `pat_o` came from group one and 1 when it came from group two.
- R5: A write to the control register that clears bit 1 while it was set restarts output sequencing: the flag reads 0 and the next counted edge presents group-one stage 0.
- R6: Writing to address 0 (group one) or address 1 (group two) stores the data at that group's write pointer, which then advances and wraps after stage 9. Data written to a group after its stage 0 has been presented in the current pass appears only on that group's next pass.
- R7: `pat_o` changes only on a counted edge, three clock cycles after the input transition (two synchronizer flops plus the output register). Between counted edges it holds its last value.
- R8: Control register bit 2 selects the interrupt source: 0 uses rising edges of `strobe_i`, and 1 uses the moment `pat_o` becomes equal to the compare register at address 3. `irq_o` is a one-cycle pulse in the cycle after that edge, and the source that is not selected raises nothing.
- R9: Each `irq_o` pulse sets `irq_sticky_o`. Writing a value with bit 0 set to address 4 clears it.
- R10: After reset `pat_o` is 0, `grp_flag_o` is 0, `irq_o` is 0 and `irq_sticky_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 group-one push, 1 group-two push, 2 control, 3 compare, 4 sticky clear |
| wr_data_i | input | PAT_W | Write data |
| pulse_i | input | 1 | Asynchronous stepping pulse input |
| strobe_i | input | 1 | Synchronous strobe used as an interrupt source |
| pat_o | output | PAT_W | Current output pattern |
| grp_flag_o | output | 1 | Group that produced the current pattern |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| irq_sticky_o | output | 1 | Latched interrupt status |

## Verification
The hardest condition to reach from the ports is a write into the group that is currently playing, made after its pass has started. To observe it, the group must be mid-pass and the bench must then follow the sequence through the rest of that pass, all of the other group, and back again. The bench gets there by playing one full twenty-step loop plus one step, so that group one is one stage into a new pass. It then overwrites all ten group-one stages. Old data must appear for the remaining nine stages, and new data must appear only after the ten group-two stages. The restart by mode toggle is reached the same way: the bench first enters single-group mode and plays part of a pass, so that a missing restart would show up as a wrong next pattern.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [2:0] {
      ADR_GRP1 = 3'd0,
      ADR_GRP2 = 3'd1,
      ADR_CTRL = 3'd2,
      ADR_CMP  = 3'd3,
      ADR_CLR  = 3'd4
   } dps_addr_e;

   typedef struct packed {
      logic irq_on_match;
      logic single_grp;
      logic edge_fall;
   } dps_ctrl_t;

   localparam int unsigned NUM_GRP = 2;

endpackage

// File: rtl/dps_edge_det.sv
module dps_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   input  logic fall_sel_i,
   output logic edge_o
);

   localparam int unsigned SH_W = SYNC_STAGES + 1;

   logic [SH_W-1:0] shift_q;
   logic            cur_lvl;
   logic            prev_lvl;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shift_q <= '0;
      end else begin
         shift_q <= {shift_q[SH_W-2:0], async_i};
      end
   end

   assign cur_lvl  = shift_q[SYNC_STAGES-1];
   assign prev_lvl = shift_q[SYNC_STAGES];

   always_comb begin
      if (fall_sel_i) edge_o = prev_lvl & ~cur_lvl;
      else            edge_o = cur_lvl & ~prev_lvl;
   end

endmodule

// File: rtl/dps_group.sv
module dps_group #(
   parameter int unsigned PAT_W  = 8,
   parameter int unsigned STAGES = 10,
   localparam int unsigned IDX_W = $clog2(STAGES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [PAT_W-1:0] wr_data_i,
   input  logic             load_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [PAT_W-1:0] rd_data_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(STAGES - 1);

   logic [PAT_W-1:0] wr_mem   [STAGES];
   logic [PAT_W-1:0] play_mem [STAGES];
   logic [IDX_W-1:0] wptr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wptr_q <= '0;
         for (int i = 0; i < int'(STAGES); i++) begin
            wr_mem[i]   <= '0;
            play_mem[i] <= '0;
         end
      end else begin
         if (load_i) begin
            for (int i = 0; i < int'(STAGES); i++) play_mem[i] <= wr_mem[i];
         end
         if (wr_i) begin
            wr_mem[wptr_q] <= wr_data_i;
            wptr_q         <= (wptr_q == LAST) ? '0 : wptr_q + IDX_W'(1);
         end
      end
   end

   // Stage 0 is read from the live store, since the snapshot is taken on that step.
   assign rd_data_o = (rd_idx_i == '0) ? wr_mem[0] : play_mem[rd_idx_i];

endmodule

// File: rtl/dps_seq.sv
module dps_seq #(
   parameter int unsigned PAT_W  = 8,
   parameter int unsigned STAGES = 10,
   localparam int unsigned IDX_W = $clog2(STAGES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             adv_i,
   input  logic             single_i,
   input  logic             restart_i,
   input  logic [PAT_W-1:0] g1_data_i,
   input  logic [PAT_W-1:0] g2_data_i,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic             nxt_grp_o,
   output logic [1:0]       load_o,
   output logic [PAT_W-1:0] pat_o,
   output logic             flag_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(STAGES - 1);

   logic [IDX_W-1:0] idx_q;
   logic             grp_q;
   logic             rd_grp;
   logic             step;

   assign rd_grp = single_i ? 1'b0 : grp_q;
   assign step   = adv_i & ~restart_i;

   assign load_o[0] = step & (idx_q == '0) & ~rd_grp;
   assign load_o[1] = step & (idx_q == '0) &  rd_grp;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q  <= '0;
         grp_q  <= 1'b0;
         flag_o <= 1'b0;
         pat_o  <= '0;
      end else if (restart_i) begin
         idx_q  <= '0;
         grp_q  <= 1'b0;
         flag_o <= 1'b0;
      end else if (adv_i) begin
         pat_o  <= rd_grp ? g2_data_i : g1_data_i;
         flag_o <= rd_grp;
         if (idx_q == LAST) begin
            idx_q <= '0;
            grp_q <= single_i ? 1'b0 : ~rd_grp;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
            grp_q <= rd_grp;
         end
      end
   end

   assign rd_idx_o  = idx_q;
   assign nxt_grp_o = grp_q;

endmodule

// File: rtl/dps_irq.sv
module dps_irq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic on_match_i,
   input  logic match_i,
   input  logic strobe_i,
   input  logic clr_i,
   output logic irq_o,
   output logic sticky_o
);

   logic src;
   logic src_d;
   logic rise;

   assign src  = on_match_i ? match_i : strobe_i;
   assign rise = src & ~src_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_d    <= 1'b0;
         irq_o    <= 1'b0;
         sticky_o <= 1'b0;
      end else begin
         src_d    <= src;
         irq_o    <= rise;
         sticky_o <= rise | (sticky_o & ~clr_i);
      end
   end

endmodule

// File: rtl/dual_pattern_seq.sv
module dual_pattern_seq
   import dps_pkg::*;
#(
   parameter int unsigned PAT_W       = 8,
   parameter int unsigned STAGES      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [PAT_W-1:0] wr_data_i,
   input  logic             pulse_i,
   input  logic             strobe_i,
   output logic [PAT_W-1:0] pat_o,
   output logic             grp_flag_o,
   output logic             irq_o,
   output logic             irq_sticky_o
);

   localparam int unsigned IDX_W = $clog2(STAGES);

   initial begin : p_param_chk
      assert (STAGES >= 2) else $error("STAGES must be at least 2");
      assert (PAT_W >= 3) else $error("PAT_W must hold the control bits");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   dps_ctrl_t        ctrl_q;
   logic [PAT_W-1:0] cmp_q;
   logic             wr_ctrl;
   logic             restart;
   logic             single_q;
   logic             adv;
   logic             match;
   logic             clr;
   logic [IDX_W-1:0] nxt_idx;
   logic             nxt_grp;
   logic [1:0]       grp_load;
   logic [1:0]       grp_wr;
   logic [PAT_W-1:0] grp_rd [NUM_GRP];

   assign wr_ctrl  = wr_en_i && (wr_addr_i == ADR_CTRL);
   assign restart  = wr_ctrl && ctrl_q.single_grp && !wr_data_i[1];
   assign single_q = ctrl_q.single_grp;
   assign clr      = wr_en_i && (wr_addr_i == ADR_CLR) && wr_data_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == ADR_CTRL) ctrl_q <= dps_ctrl_t'(wr_data_i[2:0]);
         if (wr_addr_i == ADR_CMP)  cmp_q  <= wr_data_i;
      end
   end

   dps_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .async_i    (pulse_i),
      .fall_sel_i (ctrl_q.edge_fall),
      .edge_o     (adv)
   );

   assign grp_wr[0] = wr_en_i && (wr_addr_i == ADR_GRP1);
   assign grp_wr[1] = wr_en_i && (wr_addr_i == ADR_GRP2);

   for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_grp
      dps_group #(.PAT_W(PAT_W), .STAGES(STAGES)) grp_i (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .wr_i      (grp_wr[g]),
         .wr_data_i (wr_data_i),
         .load_i    (grp_load[g]),
         .rd_idx_i  (nxt_idx),
         .rd_data_o (grp_rd[g])
      );
   end

   dps_seq #(.PAT_W(PAT_W), .STAGES(STAGES)) seq_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (adv),
      .single_i  (single_q),
      .restart_i (restart),
      .g1_data_i (grp_rd[0]),
      .g2_data_i (grp_rd[1]),
      .rd_idx_o  (nxt_idx),
      .nxt_grp_o (nxt_grp),
      .load_o    (grp_load),
      .pat_o     (pat_o),
      .flag_o    (grp_flag_o)
   );

   assign match = (pat_o == cmp_q);

   dps_irq irq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .on_match_i (ctrl_q.irq_on_match),
      .match_i    (match),
      .strobe_i   (strobe_i),
      .clr_i      (clr),
      .irq_o      (irq_o),
      .sticky_o   (irq_sticky_o)
   );

endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
   parameter int unsigned PAT_W  = 8,
   parameter int unsigned STAGES = 10,
   localparam int unsigned IDX_W = $clog2(STAGES)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             adv,
   input logic             single_q,
   input logic [IDX_W-1:0] nxt_idx,
   input logic             nxt_grp,
   input logic [PAT_W-1:0] pat_o,
   input logic             grp_flag_o,
   input logic             irq_o,
   input logic             irq_sticky_o
);

   AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nxt_idx < IDX_W'(STAGES)); // R2

   AST_SINGLE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(adv && single_q) |-> !grp_flag_o); // R3

   AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(single_q) && !single_q) |-> (nxt_idx == '0 && !nxt_grp && !grp_flag_o)); // R5

   AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(adv) |-> $stable(pat_o)); // R7

   AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o); // R8

   AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> irq_sticky_o); // R9

endmodule

bind dual_pattern_seq dps_chk #(.PAT_W(PAT_W), .STAGES(STAGES)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .adv          (adv),
   .single_q     (single_q),
   .nxt_idx      (nxt_idx),
   .nxt_grp      (nxt_grp),
   .pat_o        (pat_o),
   .grp_flag_o   (grp_flag_o),
   .irq_o        (irq_o),
   .irq_sticky_o (irq_sticky_o)
);

// File: tb/dual_pattern_seq_tb_top.sv
module dual_pattern_seq_tb_top;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [2:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic       pulse_i = 1'b0;
   logic       strobe_i = 1'b0;
   logic [7:0] pat_o;
   logic       grp_flag_o;
   logic       irq_o;
   logic       irq_sticky_o;

   int n_chk = 0;
   int n_err = 0;
   int irq_cnt = 0;
   bit done = 1'b0;

   always #5 clk_i = ~clk_i;

   dual_pattern_seq dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en_i),
      .wr_addr_i    (wr_addr_i),
      .wr_data_i    (wr_data_i),
      .pulse_i      (pulse_i),
      .strobe_i     (strobe_i),
      .pat_o        (pat_o),
      .grp_flag_o   (grp_flag_o),
      .irq_o        (irq_o),
      .irq_sticky_o (irq_sticky_o)
   );

   always @(negedge clk_i) if (rst_ni && irq_o) irq_cnt++;

   // Expected {flag, pattern} after each counted edge of one twenty-step loop.
   localparam logic [8:0] EXP_T [20] = '{
      9'h010, 9'h011, 9'h012, 9'h013, 9'h014, 9'h015, 9'h016, 9'h017, 9'h018, 9'h019,
      9'h120, 9'h121, 9'h122, 9'h123, 9'h124, 9'h125, 9'h126, 9'h127, 9'h128, 9'h129
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk_i);
      wr_en_i   = 1'b1;
      wr_addr_i = a;
      wr_data_i = d;
      @(negedge clk_i);
      wr_en_i   = 1'b0;
   endtask

   task automatic set_pulse(input logic lvl);
      @(negedge clk_i);
      pulse_i = lvl;
      repeat (4) @(negedge clk_i);
   endtask

   task automatic full_pulse();
      set_pulse(1'b1);
      set_pulse(1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk_i);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      int base;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R10 reset state
      chk("R10 pat", pat_o, 0);
      chk("R10 flag", grp_flag_o, 0);
      chk("R10 irq", irq_o, 0);
      chk("R10 sticky", irq_sticky_o, 0);

      for (int i = 0; i < 10; i++) reg_wr(3'd0, 8'h10 + 8'(i));
      for (int i = 0; i < 10; i++) reg_wr(3'd1, 8'h20 + 8'(i));

      // R1 rising edge counts by default, falling edge does not
      set_pulse(1'b1);
      chk("R1 rise counted", {grp_flag_o, pat_o}, EXP_T[0]);
      set_pulse(1'b0);
      chk("R1 fall ignored", {grp_flag_o, pat_o}, EXP_T[0]);

      // R2 R4 table walk over the twenty-step loop
      for (int k = 1; k < 20; k++) begin
         full_pulse();
         chk("R2 R4 sequence", {grp_flag_o, pat_o}, EXP_T[k]);
      end
      full_pulse();
      chk("R2 loop repeats", {grp_flag_o, pat_o}, 9'h010);

      // R6 write into the playing group only shows on its next pass
      for (int i = 0; i < 10; i++) reg_wr(3'd0, 8'h30 + 8'(i));
      full_pulse();
      chk("R6 old data kept", pat_o, 8'h11);
      repeat (8) full_pulse();
      chk("R6 old pass end", pat_o, 8'h19);
      full_pulse();
      chk("R4 group two flag", {grp_flag_o, pat_o}, 9'h120);
      repeat (9) full_pulse();
      full_pulse();
      chk("R6 new data next pass", {grp_flag_o, pat_o}, 9'h030);

      // R1 falling edge select
      reg_wr(3'd2, 8'h01);
      set_pulse(1'b1);
      chk("R1 rise ignored", pat_o, 8'h30);
      set_pulse(1'b0);
      chk("R1 fall counted", pat_o, 8'h31);

      // R7 output holds with no counted edge
      repeat (20) @(negedge clk_i);
      chk("R7 hold", pat_o, 8'h31);

      // R3 single-group loop
      reg_wr(3'd2, 8'h03);
      repeat (8) full_pulse();
      chk("R3 end of group one", {grp_flag_o, pat_o}, 9'h039);
      full_pulse();
      chk("R3 wraps to group one", {grp_flag_o, pat_o}, 9'h030);
      repeat (3) full_pulse();
      chk("R3 mid pass", pat_o, 8'h33);

      // R5 restart by clearing the mode bit
      reg_wr(3'd2, 8'h01);
      chk("R5 flag after restart", grp_flag_o, 0);
      full_pulse();
      chk("R5 restart at stage 0", {grp_flag_o, pat_o}, 9'h030);

      // R8 R9 strobe source
      @(negedge clk_i);
      strobe_i = 1'b1;
      @(negedge clk_i);
      chk("R8 strobe pulse", irq_o, 1);
      @(negedge clk_i);
      chk("R8 one cycle", irq_o, 0);
      strobe_i = 1'b0;
      chk("R9 sticky set", irq_sticky_o, 1);
      reg_wr(3'd4, 8'h01);
      chk("R9 sticky cleared", irq_sticky_o, 0);

      // R8 match ignored while strobe is selected
      reg_wr(3'd3, 8'h31);
      base = irq_cnt;
      full_pulse();
      repeat (3) @(negedge clk_i);
      chk("R8 match ignored pat", pat_o, 8'h31);
      chk("R8 match ignored", irq_cnt, base);
      chk("R9 no sticky", irq_sticky_o, 0);

      // R8 match source
      reg_wr(3'd3, 8'h32);
      reg_wr(3'd2, 8'h05);
      base = irq_cnt;
      full_pulse();
      repeat (3) @(negedge clk_i);
      chk("R8 match irq", irq_cnt, base + 1);
      chk("R9 sticky on match", irq_sticky_o, 1);
      @(negedge clk_i);
      strobe_i = 1'b1;
      repeat (3) @(negedge clk_i);
      strobe_i = 1'b0;
      repeat (2) @(negedge clk_i);
      chk("R8 strobe ignored", irq_cnt, base + 1);

      finish_run();
   end

endmodule